// File: doc/BRIEF.md
# Configurable Multi-Level Routing Multiplexer

This block steers one of N data inputs to a single output, the way a routing switch in a programmable fabric does. There is no binary select. Each edge of each small branch multiplexer is enabled by a configuration bit, and the way bits are laid out depends on a structure picked at elaboration. The flat structure is one wide branch. The binary structure is a tree of 2-input branches. The staged structure has a chosen branch width and level count.

The staged and binary structures are grown from the output back toward the inputs. Growth stops as soon as N leaves exist. As a result, the last branch built can be partly filled, and some inputs can hang directly off a branch one level above the bottom. The configuration is checked every cycle. If no single path is enabled, or any branch has more than one edge enabled, the output is forced low and an error flag is raised. Output and flag pass through an optional register that has a synchronous reset.

Top module: `route_mux`

## Requirements
- R1: In the flat structure, cfg has N bits and bit i set to 1 connects din[i]. When exactly one bit is set, the output equals that input. Any other count of set bits is an error.
- R2: In the binary structure, the level count is ceil(log2 N) and there is one cfg bit per level, where level 0 is nearest the inputs. Every branch on level k uses bit k: its first edge is enabled when the bit is 1, and its second edge when the bit is 0. For N=5, the patterns cfg[2:0] = 111, 110, 10x, 01x and 00x select inputs 0, 1, 2, 3 and 4. This structure never reports an error.
- R3: In the staged structure with branch width B, the edge at position i of any branch on level k is enabled by cfg[k*B+i] = 1.
- R4: Input numbering starts with the leaves on level 0 in creation order, then continues with the leaves on the level above. For N=6, B=3 with 2 levels, inputs 0 to 4 sit on level 0 and input 5 sits at position 2 of the output branch. The second level-0 branch holds only inputs 3 and 4, at positions 0 and 1.
- R5: If the enabled edges do not form a path from any input to the output, dout is 0 and err is 1. Examples are an all-zero cfg in the flat or staged structure, or selecting the missing third position of a partly filled branch.
- R6: If any branch, on the path or off it, has more than one edge enabled, dout is 0 and err is 1.
- R7: With the output register enabled, dout and err reflect the inputs sampled at the previous rising clock edge. While rst is high at an edge, both are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | N | Data inputs |
| cfg | input | CFGW | Configuration bits; width follows the structure (N, ceil(log2 N), or B*levels) |
| dout | output | 1 | Selected data, 0 when the configuration is invalid |
| err | output | 1 | High when no unique path exists or a branch has a clash |

## Verification
Suppose a branch is wired to the wrong child, or a leaf takes the wrong input index. Then a one-hot data pattern driven on the expected input will fail to appear one clock later, and its complement will fail to return zero on the same cycle. A wrong bit-sharing or inversion rule shows up as the wrong input winning for a specific cfg pattern. A broken clash or path detector shows up as err staying low, and dout echoing data, on the very next cycle after an invalid pattern. Because every result is registered exactly once, all of these faults become visible on the first edge after the stimulus.

// File: rtl/route_mux_pkg.sv
package route_mux_pkg;

    typedef enum logic [1:0] {
        SHAPE_FLAT,
        SHAPE_BINARY,
        SHAPE_STAGED
    } shape_e;

    // Value and path-liveness of one graph node.
    typedef struct packed {
        logic val;
        logic live;
    } node_t;

    function automatic int eff_branch(shape_e shape, int n, int b);
        if (shape == SHAPE_FLAT)   return n;
        if (shape == SHAPE_BINARY) return 2;
        return b;
    endfunction

    function automatic int eff_levels(shape_e shape, int n, int l);
        if (shape == SHAPE_FLAT)   return 1;
        if (shape == SHAPE_BINARY) return $clog2(n);
        return l;
    endfunction

    function automatic int cfg_bits(shape_e shape, int n, int b, int l);
        if (shape == SHAPE_BINARY) return eff_levels(shape, n, l);
        return eff_branch(shape, n, b) * eff_levels(shape, n, l);
    endfunction

    // Node count at a level, following growth from the output downward.
    function automatic int level_nodes(int n, int b, int l, int lvl);
        int total;
        int prev;
        int cur;
        int r;
        int f;
        int m;
        if (lvl >= l) return 1;
        total = 0;
        prev  = 1;
        cur   = 0;
        for (int k = l - 1; k >= lvl; k--) begin
            if (k == l - 1) begin
                cur   = (n < b) ? n : b;
                total = cur;
            end else begin
                r = n - total;
                if (r <= 0) begin
                    cur = 0;
                end else if (r > prev * (b - 1)) begin
                    cur   = prev * b;
                    total = total + prev * (b - 1);
                end else begin
                    f     = (r - 1) / (b - 1);
                    m     = r - f * (b - 1);
                    cur   = f * b + m + 1;
                    total = n;
                end
            end
            prev = cur;
        end
        return cur;
    endfunction

    // Nodes on level lvl+1 that act as branches over level lvl.
    function automatic int level_parents(int n, int b, int l, int lvl);
        return (level_nodes(n, b, l, lvl) + b - 1) / b;
    endfunction

    // First input index used by the leaves on a level.
    function automatic int leaf_base(int n, int b, int l, int lvl);
        int s;
        s = 0;
        for (int k = 0; k < lvl; k++) begin
            s = s + level_nodes(n, b, l, k)
                  - ((k == 0) ? 0 : level_parents(n, b, l, k - 1));
        end
        return s;
    endfunction

endpackage

// File: rtl/route_mux_decode.sv
module route_mux_decode
    import route_mux_pkg::*;
#(
    parameter shape_e SHAPE = SHAPE_STAGED,
    parameter int     BW    = 3,
    parameter int     LV    = 2,
    parameter int     CFGW  = 6
) (
    input  logic [CFGW-1:0]         cfg,
    output logic [LV-1:0][BW-1:0]   en
);

    for (genvar k = 0; k < LV; k++) begin : g_lvl
        for (genvar i = 0; i < BW; i++) begin : g_pos
            if (SHAPE == SHAPE_BINARY) begin : g_shared
                if (i == 0) begin : g_first
                    assign en[k][i] = cfg[k];
                end else begin : g_second
                    assign en[k][i] = ~cfg[k];
                end
            end else begin : g_own
                assign en[k][i] = cfg[k*BW + i];
            end
        end
    end

endmodule

// File: rtl/route_mux_branch.sv
module route_mux_branch
    import route_mux_pkg::*;
#(
    parameter int K = 2
) (
    input  logic [K-1:0] kid_val,
    input  logic [K-1:0] kid_live,
    input  logic [K-1:0] en,
    output node_t        res,
    output logic         clash
);

    int hits;

    always_comb begin
        hits     = $countones(en);
        res.val  = |(en & kid_val);
        res.live = (hits == 1) && (|(en & kid_live));
        clash    = (hits > 1);
    end

endmodule

// File: rtl/route_mux.sv
module route_mux
    import route_mux_pkg::*;
#(
    parameter int     N       = 6,
    parameter shape_e SHAPE   = SHAPE_STAGED,
    parameter int     BRANCH  = 3,
    parameter int     LEVELS  = 2,
    parameter bit     REG_OUT = 1'b1,
    localparam int    CFGW    = cfg_bits(SHAPE, N, BRANCH, LEVELS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    din,
    input  logic [CFGW-1:0] cfg,
    output logic            dout,
    output logic            err
);

    localparam int BW = eff_branch(SHAPE, N, BRANCH);
    localparam int LV = eff_levels(SHAPE, N, LEVELS);

    logic [LV-1:0][BW-1:0] en;
    node_t                 nodes [LV+1][N];
    logic [LV-1:0][N-1:0]  clash_map;
    logic                  path_ok;
    logic                  sel_val;

    route_mux_decode #(
        .SHAPE (SHAPE),
        .BW    (BW),
        .LV    (LV),
        .CFGW  (CFGW)
    ) u_decode (
        .cfg (cfg),
        .en  (en)
    );

    for (genvar lvl = 0; lvl <= LV; lvl++) begin : g_lvl
        localparam int CNT       = level_nodes(N, BW, LV, lvl);
        localparam int PAR_BELOW = (lvl == 0) ? 0 : level_parents(N, BW, LV, lvl - 1);
        for (genvar j = 0; j < N; j++) begin : g_node
            if (j >= CNT) begin : g_absent
                assign nodes[lvl][j] = '0;
                if (lvl > 0) begin : g_noclash
                    assign clash_map[lvl-1][j] = 1'b0;
                end
            end else if (j >= PAR_BELOW) begin : g_leaf
                localparam int IDX = leaf_base(N, BW, LV, lvl) + j - PAR_BELOW;
                assign nodes[lvl][j].val  = din[IDX];
                assign nodes[lvl][j].live = 1'b1;
                if (lvl > 0) begin : g_noclash
                    assign clash_map[lvl-1][j] = 1'b0;
                end
            end else begin : g_branch
                localparam int BELOW = level_nodes(N, BW, LV, lvl - 1);
                localparam int KCNT  = (BELOW - j*BW < BW) ? (BELOW - j*BW) : BW;
                logic [KCNT-1:0] kv;
                logic [KCNT-1:0] kl;
                logic [KCNT-1:0] ke;
                for (genvar c = 0; c < KCNT; c++) begin : g_kid
                    assign kv[c] = nodes[lvl-1][j*BW + c].val;
                    assign kl[c] = nodes[lvl-1][j*BW + c].live;
                    assign ke[c] = en[lvl-1][c];
                end
                route_mux_branch #(
                    .K (KCNT)
                ) u_branch (
                    .kid_val  (kv),
                    .kid_live (kl),
                    .en       (ke),
                    .res      (nodes[lvl][j]),
                    .clash    (clash_map[lvl-1][j])
                );
            end
        end
    end

    assign path_ok = nodes[LV][0].live && !(|clash_map);
    assign sel_val = path_ok && nodes[LV][0].val;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                dout <= 1'b0;
                err  <= 1'b0;
            end else begin
                dout <= sel_val;
                err  <= !path_ok;
            end
        end

        // R7: first cycle out of reset still shows the cleared register
        a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (dout == 1'b0) && (err == 1'b0));

        // R5 and R6: a flagged result never carries data
        a_r5_err_quiet: assert property (@(posedge clk) disable iff (rst)
            err |-> (dout == 1'b0));

        if (SHAPE == SHAPE_FLAT) begin : g_flat_chk
            a_r1_flat_pick: assert property (@(posedge clk) disable iff (rst)
                ($past(rst) == 1'b0) && ($past($countones(cfg)) == 1)
                |-> (dout == $past(|(cfg & din))) && (err == 1'b0));
            a_r1_flat_count: assert property (@(posedge clk) disable iff (rst)
                ($past(rst) == 1'b0) && ($past($countones(cfg)) != 1)
                |-> err);
        end

        if (SHAPE == SHAPE_BINARY) begin : g_tree_chk
            a_r2_tree_clean: assert property (@(posedge clk) disable iff (rst)
                err == 1'b0);
        end else begin : g_zero_chk
            a_r5_empty_cfg: assert property (@(posedge clk) disable iff (rst)
                ($past(rst) == 1'b0) && ($past(cfg) == '0)
                |-> err && (dout == 1'b0));
        end
    end else begin : g_comb
        assign dout = sel_val;
        assign err  = !path_ok;
    end

endmodule

// File: tb/route_mux_test.sv
`timescale 1ns/1ps
module route_mux_test;
    import route_mux_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] s_din, s_cfg;
    logic [4:0] t_din;
    logic [2:0] t_cfg;
    logic [3:0] f_din, f_cfg;
    logic       s_out, s_err, t_out, t_err, f_out, f_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int    dut;
        logic  e_out;
        logic  e_err;
        int    due;
        string tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    route_mux #(.N(6), .SHAPE(SHAPE_STAGED), .BRANCH(3), .LEVELS(2)) uut (
        .clk(clk), .rst(rst), .din(s_din), .cfg(s_cfg), .dout(s_out), .err(s_err));
    route_mux #(.N(5), .SHAPE(SHAPE_BINARY), .BRANCH(2), .LEVELS(3)) uut_tree (
        .clk(clk), .rst(rst), .din(t_din), .cfg(t_cfg), .dout(t_out), .err(t_err));
    route_mux #(.N(4), .SHAPE(SHAPE_FLAT), .BRANCH(4), .LEVELS(1)) uut_flat (
        .clk(clk), .rst(rst), .din(f_din), .cfg(f_cfg), .dout(f_out), .err(f_err));

    task automatic check(input logic ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got out/err=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(input int d, input logic [7:0] c, input logic [7:0] x,
                         input logic eo, input logic ee, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        case (d)
            0: begin s_cfg = c[5:0]; s_din = x[5:0]; end
            1: begin t_cfg = c[2:0]; t_din = x[4:0]; end
            default: begin f_cfg = c[3:0]; f_din = x[3:0]; end
        endcase
        e.dut = d; e.e_out = eo; e.e_err = ee; e.due = cyc + 1; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops each expectation once its capture edge has passed
    always @(negedge clk) begin
        exp_t e;
        logic [1:0] act;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            case (e.dut)
                0: act = {s_out, s_err};
                1: act = {t_out, t_err};
                default: act = {f_out, f_err};
            endcase
            check(act == {e.e_out, e.e_err}, e.tag, act, {e.e_out, e.e_err});
        end
    end

    logic [5:0] s_tab [6];
    logic [2:0] t_tab [8];
    int         t_idx [8];

    task automatic run_all();
        // R3 and R4: each staged input reached through its own bit pair
        for (int i = 0; i < 6; i++) begin
            apply(0, {2'b0, s_tab[i]}, 8'(1 << i), 1'b1, 1'b0, (i == 5) ? "R4 upper leaf one-hot" : "R3 one-hot");
            apply(0, {2'b0, s_tab[i]}, ~8'(1 << i), 1'b0, 1'b0, (i == 5) ? "R4 upper leaf complement" : "R3 complement");
        end
        // R4: level-0 bits do not disturb the leaf at the upper level
        apply(0, 8'b100001, 8'b100000, 1'b1, 1'b0, "R4 leaf ignores level0");
        // R5: partial branch has no third edge
        apply(0, 8'b010100, 8'hff, 1'b0, 1'b1, "R5 missing edge in short branch");
        apply(0, 8'b000000, 8'hff, 1'b0, 1'b1, "R5 empty cfg staged");
        // R6: clashes on the path and off it
        apply(0, 8'b011001, 8'hff, 1'b0, 1'b1, "R6 two edges level1");
        apply(0, 8'b100011, 8'hff, 1'b0, 1'b1, "R6 two edges level0 off path");
        // R7: result delayed by exactly one edge
        apply(0, {2'b0, s_tab[0]}, 8'h01, 1'b1, 1'b0, "R7 latency setup");
        apply(0, {2'b0, s_tab[0]}, 8'h00, 1'b0, 1'b0, "R7 latency new");
        @(negedge clk);
        check(s_out == 1'b1, "R7 output holds before edge", {s_out, s_err}, 2'b10);
        // R2: shared, inverted tree bits
        for (int i = 0; i < 8; i++) begin
            apply(1, {5'b0, t_tab[i]}, 8'(1 << t_idx[i]), 1'b1, 1'b0, "R2 tree one-hot");
            apply(1, {5'b0, t_tab[i]}, ~8'(1 << t_idx[i]), 1'b0, 1'b0, "R2 tree complement");
        end
        // R1: flat selection and bit-count errors
        for (int i = 0; i < 4; i++) begin
            apply(2, 8'(1 << i), 8'(1 << i), 1'b1, 1'b0, "R1 flat one-hot");
            apply(2, 8'(1 << i), ~8'(1 << i), 1'b0, 1'b0, "R1 flat complement");
        end
        apply(2, 8'b0000, 8'hff, 1'b0, 1'b1, "R1 R5 flat empty");
        apply(2, 8'b0101, 8'hff, 1'b0, 1'b1, "R1 R6 flat two bits");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        s_tab = '{6'b001001, 6'b001010, 6'b001100, 6'b010001, 6'b010010, 6'b100000};
        t_tab = '{3'b111, 3'b110, 3'b100, 3'b101, 3'b010, 3'b011, 3'b000, 3'b001};
        t_idx = '{0, 1, 2, 2, 3, 3, 4, 4};
        s_cfg = 6'b001001; s_din = '1;
        t_cfg = 3'b111;    t_din = '1;
        f_cfg = 4'b0001;   f_din = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(s_out == 1'b0 && s_err == 1'b0, "R7 reset staged", {s_out, s_err}, 2'b00);
        check(t_out == 1'b0 && t_err == 1'b0, "R7 reset tree", {t_out, t_err}, 2'b00);
        check(f_out == 1'b0 && f_err == 1'b0, "R7 reset flat", {f_out, f_err}, 2'b00);
        @(posedge clk);
        #1 rst = 1'b0;
        fork
            run_all();
            begin
                #100000;
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, got timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule